// File: doc/BRIEF.md
# Two-Source 128-bit Lane Permute Unit

This unit forms a 256-bit result from two 256-bit operands. The two operands are treated as one pool of four 128-bit lanes, and an 8-bit control byte picks the lanes. Each half of the result has its own 2-bit index into that pool and its own bit that forces the half to zero. Both halves may name the same lane. No element smaller than 128 bits is ever taken from either operand.

An upstream stage presents the operands and the control byte with a valid strobe. One clock later, the result appears in a register together with an output valid flag. When the strobe is low, the result register keeps its previous contents.

Top module: `lane_pick_unit`

## Requirements
- R1: Lane numbering for the index fields is as follows. Index 0 is srcA[127:0], index 1 is srcA[255:128], index 2 is srcB[127:0] and index 3 is srcB[255:128]. ctrlByte[1:0] chooses the lane that drives result[127:0].
- R2: ctrlByte[5:4] uses the same lane numbering to choose the lane that drives result[255:128].
- R3: When ctrlByte[3] is 1, result[127:0] is all zeros, whatever ctrlByte[1:0] holds.
- R4: When ctrlByte[7] is 1, result[255:128] is all zeros, whatever ctrlByte[5:4] holds.
- R5: ctrlByte[2] and ctrlByte[6] have no effect on the result.
- R6: Both halves may select the same lane, and that lane then appears in both halves.
- R7: A result is captured on a rising clock edge where inValid is 1. outValid is 1 in the cycle after an accepted input and 0 in the cycle after a cycle where inValid is 0.
- R8: While inValid is 0, result keeps its previous value.
- R9: While rstN is 0, on a rising edge (synchronous reset), result and outValid are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands and control byte are valid this cycle |
| srcA | input | 256 | First operand (lanes 0 and 1) |
| srcB | input | 256 | Second operand (lanes 2 and 3) |
| ctrlByte | input | 8 | Lane indices and zero-force bits |
| outValid | output | 1 | result holds a newly captured value |
| result | output | 256 | Registered permuted result |

## Verification
Every one of the 256 control byte values is applied with fresh random operands, so all lane and zero combinations are covered for both halves. Because each of the four lanes holds distinct random data, a wrong lane index, a swapped source, or a swapped half shows up as a data mismatch. Dedicated patterns cover:
- the same lane chosen for both halves;
- both zero bits set over nonzero operands;
- control bytes that differ only in bits 2 and 6, which must give identical results;
- idle cycles with changing inputs, which must leave the result unchanged.

// File: rtl/lane_pick_pkg.sv
package lane_pick_pkg;
  parameter int LANE_W    = 128;
  parameter int NUM_HALF  = 2;
  parameter int NUM_LANE  = 2 * NUM_HALF;
  parameter int IDX_W     = $clog2(NUM_LANE);
  parameter int NIB_W     = 4;
  parameter int CTRL_W    = NIB_W * NUM_HALF;
  parameter int DATA_W    = LANE_W * NUM_HALF;
  parameter int ZERO_POS  = NIB_W - 1;

  typedef struct packed {
    logic                           load;
    logic [NUM_HALF-1:0][IDX_W-1:0] laneSel;
    logic [NUM_HALF-1:0]            zeroHalf;
  } permCtrlT;
endpackage

// File: rtl/lane_pick_ctrl.sv
module lane_pick_ctrl
  import lane_pick_pkg::*;
(
  input  logic              inValid,
  input  logic [CTRL_W-1:0] ctrlByte,
  output permCtrlT          strobes
);
  logic [NUM_HALF-1:0][IDX_W-1:0] selField;
  logic [NUM_HALF-1:0]            zeroField;

  // One nibble per half: index in the low bits, zero-force in the top bit.
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_nib
    assign selField[h]  = ctrlByte[h*NIB_W +: IDX_W];
    assign zeroField[h] = ctrlByte[h*NIB_W + ZERO_POS];
  end

  always_comb begin
    strobes.load     = inValid;
    strobes.laneSel  = selField;
    strobes.zeroHalf = zeroField;
  end
endmodule

// File: rtl/lane_pick_dp.sv
module lane_pick_dp
  import lane_pick_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  permCtrlT          strobes,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  logic [NUM_LANE-1:0][LANE_W-1:0] lanePool;
  logic [NUM_HALF-1:0][LANE_W-1:0] nextHalf;
  logic [NUM_HALF-1:0][LANE_W-1:0] resReg;
  logic                            validReg;

  // Joined operands: srcA supplies the low lanes, srcB the high lanes.
  assign lanePool = {srcB, srcA};

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign nextHalf[h] = strobes.zeroHalf[h] ? '0 : lanePool[strobes.laneSel[h]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resReg   <= '0;
      validReg <= 1'b0;
    end else begin
      validReg <= strobes.load;
      if (strobes.load) resReg <= nextHalf;
    end
  end

  assign result   = resReg;
  assign outValid = validReg;
endmodule

// File: rtl/lane_pick_unit.sv
module lane_pick_unit
  import lane_pick_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [CTRL_W-1:0] ctrlByte,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  permCtrlT strobes;

  lane_pick_ctrl u_ctrl (
    .inValid (inValid),
    .ctrlByte(ctrlByte),
    .strobes (strobes)
  );

  lane_pick_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcA    (srcA),
    .srcB    (srcB),
    .strobes (strobes),
    .outValid(outValid),
    .result  (result)
  );
endmodule

// File: rtl/lane_pick_checker.sv
module lane_pick_checker
  import lane_pick_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] srcA,
  input logic [CTRL_W-1:0] ctrlByte,
  input logic              outValid,
  input logic [DATA_W-1:0] result
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (outValid == $past(inValid)));

  assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid) && $past(ctrlByte[3])) |-> (result[LANE_W-1:0] == '0));

  assert_high_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid) && $past(ctrlByte[7])) |-> (result[DATA_W-1:LANE_W] == '0));

  assert_low_lane0_R1: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid) && !$past(ctrlByte[3]) && ($past(ctrlByte[1:0]) == 2'd0))
    |-> (result[LANE_W-1:0] == $past(srcA[LANE_W-1:0])));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(inValid)) |-> $stable(result));
endmodule

bind lane_pick_unit lane_pick_checker u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .srcA    (srcA),
  .ctrlByte(ctrlByte),
  .outValid(outValid),
  .result  (result)
);

// File: tb/test_lane_pick_unit.sv
module test_lane_pick_unit;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [255:0] srcA, srcB;
  logic [7:0]   ctrlByte;
  logic         outValid;
  logic [255:0] result;
  int           nChecks = 0;
  int           nFails  = 0;

  always #4 clk = ~clk;

  lane_pick_unit i_lane_pick_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .ctrlByte(ctrlByte), .outValid(outValid), .result(result)
  );

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [127:0] laneOf(logic [255:0] a, logic [255:0] b, logic [1:0] idx);
    case (idx)
      2'd0:    return a[127:0];
      2'd1:    return a[255:128];
      2'd2:    return b[127:0];
      default: return b[255:128];
    endcase
  endfunction

  function automatic logic [255:0] model(logic [255:0] a, logic [255:0] b, logic [7:0] c);
    logic [127:0] lo, hi;
    lo = c[3] ? 128'd0 : laneOf(a, b, c[1:0]);
    hi = c[7] ? 128'd0 : laneOf(a, b, c[5:4]);
    return {hi, lo};
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one accepted input; returns after the result register has loaded.
  task automatic apply(logic [255:0] a, logic [255:0] b, logic [7:0] c);
    @(negedge clk);
    srcA = a; srcB = b; ctrlByte = c; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic test_reset();
    rstN = 1'b0; inValid = 1'b0; srcA = '1; srcB = '1; ctrlByte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 result cleared", result, '0);
    chk("R9 outValid cleared", {255'd0, outValid}, 256'd0);
    rstN = 1'b1;
  endtask

  task automatic test_all_controls();
    for (int c = 0; c < 256; c++) begin
      logic [255:0] a, b;
      a = rand256(); b = rand256();
      apply(a, b, c[7:0]);
      chk(c[3] ? "R3 low half" : "R1 low half", {128'd0, result[127:0]},
          {128'd0, model(a, b, c[7:0]) >> 0} & {128'd0, {128{1'b1}}});
      chk(c[7] ? "R4 high half" : "R2 high half", {128'd0, result[255:128]},
          {128'd0, model(a, b, c[7:0]) >> 128});
    end
  endtask

  task automatic test_same_lane();
    for (int l = 0; l < 4; l++) begin
      logic [255:0] a, b;
      logic [7:0]   c;
      a = rand256(); b = rand256();
      c = {2'b00, l[1:0], 2'b00, l[1:0]};
      apply(a, b, c);
      chk("R6 duplicated lane", result, {laneOf(a, b, l[1:0]), laneOf(a, b, l[1:0])});
    end
  endtask

  task automatic test_both_zero();
    apply('1, '1, 8'hDB);
    chk("R3 R4 both halves zero", result, '0);
  endtask

  task automatic test_ignored_bits();
    for (int k = 0; k < 8; k++) begin
      logic [255:0] a, b, first;
      logic [7:0]   c;
      a = rand256(); b = rand256();
      c = $urandom & 8'hBB;
      apply(a, b, c);
      first = result;
      apply(a, b, c | 8'h44);
      chk("R5 bits 2 and 6 ignored", result, first);
    end
  endtask

  task automatic test_latency_hold();
    logic [255:0] a, b, held;
    a = rand256(); b = rand256();
    @(negedge clk);
    srcA = a; srcB = b; ctrlByte = 8'h21; inValid = 1'b1;
    @(negedge clk);
    chk("R7 outValid one cycle later", {255'd0, outValid}, 256'd1);
    chk("R7 result captured", result, model(a, b, 8'h21));
    inValid = 1'b0;
    held = result;
    srcA = rand256(); srcB = rand256(); ctrlByte = 8'h32;
    @(negedge clk);
    chk("R7 outValid drops", {255'd0, outValid}, 256'd0);
    srcA = rand256(); ctrlByte = 8'h10;
    repeat (3) @(negedge clk);
    chk("R8 result held while idle", result, held);
  endtask

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    test_reset();
    test_latency_hold();
    test_all_controls();
    test_same_lane();
    test_both_zero();
    test_ignored_bits();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule